// File: doc/BRIEF.md
# Programmable Display Timing Generator

This block produces the raster timing for a parallel RGB pixel stream. Software programs the lengths of the four horizontal segments (sync, back porch, active, front porch) in pixels and the four vertical segments in lines, each written as its length minus one. While the block is scanning it walks every line in the order sync, back porch, active, front porch, and walks the lines of a frame in the same order. It drives horizontal sync, vertical sync and data enable, a polarity-free visible flag, and the pixel and line coordinates inside the visible area. It also passes an incoming pixel word through to the output: the word is gated to the idle level outside the visible area and inverted when the data polarity is active-low.

A command bit starts and stops scanning. On every start the counters begin at the first sync pixel of line 0. While the block is stopped, all timing outputs rest at their inactive levels. A sticky status bit marks the start of every frame's vertical sync and drives the interrupt output through a mask bit. Timing values written while the block is scanning are staged and applied only at the next frame boundary. This keeps a frame that is already in progress consistent.

Top module: `disp_timing_gen`

## Requirements
- R1: Registers 0x4, 0x5, 0x6 and 0x7 hold the horizontal sync, back-porch, active and front-porch lengths minus one. A line lasts (sum of the four values + 4) pixel cycles. It runs sync first, then back porch, then active, then front porch.
- R2: Registers 0x8, 0x9, 0xA and 0xB hold the vertical sync, back-porch, active and front-porch lengths minus one, counted in lines. The segments follow the same order as in R1. Vertical sync is asserted on every pixel of the sync lines.
- R3: Register 0x3 holds the polarities: bit 0 hsync, bit 1 vsync, bit 2 data enable, bit 3 pixel data. A set bit makes that output active-high. A clear bit makes it active-low, and for pixel data this means bitwise inversion.
- R4: Register 0x0 bit 0 is the run command. While it is 0, hsync, vsync and data enable sit at their inactive levels, the visible flag and both coordinates are 0, and the pixel output holds its idle level (all zeros when bit 3 of register 0x3 is set, all ones when it is clear).
- R5: In the first cycle after the run bit changes from 0 to 1, the block is on pixel 0 of line 0, so hsync and vsync are both active.
- R6: The visible flag is 1 exactly when both axes are in their active segment, whatever the polarities. The pixel and line outputs then give the offset from the first active pixel and the first active line, and they are 0 otherwise.
- R7: Status bit 0 of register 0x1 is set on the clock edge that ends pixel 0 of line 0 of every frame. Writing 1 to that bit clears it. If a clear and a set fall on the same edge, the set wins.
- R8: The interrupt output equals status bit 0 AND mask bit 0 of register 0x2.
- R9: A timing register written while the block is scanning leaves the current frame unchanged. The new value takes effect from the first pixel of the next frame.
- R10: The read port returns, combinationally, the value last written to registers 0x0, 0x2, 0x3 and 0x4 to 0xB, and the status bit at 0x1. Other addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address for reads and writes |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data at reg_addr_i |
| pix_data_i | input | DW | Pixel word to present |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| visible_o | output | 1 | High inside the visible area |
| pix_x_o | output | CW | Pixel offset inside the active line |
| line_y_o | output | CW | Line offset inside the active frame |
| pix_data_o | output | DW | Pixel word after gating and polarity |
| irq_o | output | 1 | Masked frame-start interrupt |

## Verification
Two events can meet on one clock edge: the status bit being set by a frame start and a software write that clears it. The bench watches its reference model for the cycle that sits on pixel 0 of line 0. It then drives the clear write in that same cycle, so both events take effect on the same edge. The status bit must read back as 1 afterwards. In a second overlap, a timing register is rewritten in the middle of a frame. The every-cycle comparison shows that the old timing holds until the frame boundary and the new timing applies from there.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int ADDR_W = 4;
  localparam int REG_W  = 32;
  localparam int NSEG   = 4;

  localparam logic [ADDR_W-1:0] A_CMD  = 4'h0;
  localparam logic [ADDR_W-1:0] A_STAT = 4'h1;
  localparam logic [ADDR_W-1:0] A_MASK = 4'h2;
  localparam logic [ADDR_W-1:0] A_POL  = 4'h3;

  // upper address bits that select a timing bank
  localparam logic [1:0] BANK_H = 2'b01;
  localparam logic [1:0] BANK_V = 2'b10;

  // segment index inside a bank; the order is the scan order
  typedef enum logic [1:0] {
    SEG_SYNC  = 2'd0,
    SEG_BACK  = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_FRONT = 2'd3
  } seg_e;

  // polarity bit positions
  localparam int POL_HS = 0;
  localparam int POL_VS = 1;
  localparam int POL_DE = 2;
  localparam int POL_PD = 3;
endpackage

// File: rtl/dtg_regs.sv
module dtg_regs
  import dtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [REG_W-1:0]              wdata_i,
  output logic [REG_W-1:0]              rdata_o,
  input  logic                          frame_start_i,
  output logic                          run_o,
  output logic [3:0]                    pol_o,
  output logic [NSEG-1:0][CW-1:0]       hseg_o,
  output logic [NSEG-1:0][CW-1:0]       vseg_o,
  output logic                          irq_o
);
  logic                    cmd_q, cmd_d;
  logic                    stat_q, stat_d;
  logic                    mask_q, mask_d;
  logic [3:0]              pol_q, pol_d;
  logic [NSEG-1:0][CW-1:0] hseg_q, hseg_d;
  logic [NSEG-1:0][CW-1:0] vseg_q, vseg_d;
  logic                    clr_hit;
  logic                    unused_wbits;

  assign unused_wbits = ^wdata_i[REG_W-1:CW];
  assign clr_hit = wr_i && (addr_i == A_STAT) && wdata_i[0];

  always_comb begin
    cmd_d  = cmd_q;
    mask_d = mask_q;
    pol_d  = pol_q;
    hseg_d = hseg_q;
    vseg_d = vseg_q;
    stat_d = stat_q;
    if (wr_i) begin
      if (addr_i == A_CMD)  cmd_d  = wdata_i[0];
      if (addr_i == A_MASK) mask_d = wdata_i[0];
      if (addr_i == A_POL)  pol_d  = wdata_i[3:0];
      if (addr_i[3:2] == BANK_H) hseg_d[addr_i[1:0]] = wdata_i[CW-1:0];
      if (addr_i[3:2] == BANK_V) vseg_d[addr_i[1:0]] = wdata_i[CW-1:0];
    end
    if (clr_hit)       stat_d = 1'b0;
    if (frame_start_i) stat_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q  <= 1'b0;
      stat_q <= 1'b0;
      mask_q <= 1'b0;
      pol_q  <= '0;
      hseg_q <= '0;
      vseg_q <= '0;
    end else begin
      cmd_q  <= cmd_d;
      stat_q <= stat_d;
      mask_q <= mask_d;
      pol_q  <= pol_d;
      hseg_q <= hseg_d;
      vseg_q <= vseg_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i[3:2])
      2'b00: begin
        case (addr_i[1:0])
          2'd0: rdata_o[0]   = cmd_q;
          2'd1: rdata_o[0]   = stat_q;
          2'd2: rdata_o[0]   = mask_q;
          default: rdata_o[3:0] = pol_q;
        endcase
      end
      BANK_H:  rdata_o[CW-1:0] = hseg_q[addr_i[1:0]];
      BANK_V:  rdata_o[CW-1:0] = vseg_q[addr_i[1:0]];
      default: rdata_o = '0;
    endcase
  end

  assign run_o  = cmd_q;
  assign pol_o  = pol_q;
  assign hseg_o = hseg_q;
  assign vseg_o = vseg_q;
  assign irq_o  = stat_q & mask_q;

  AST_STAT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start_i |=> stat_q); // R7
  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr_hit) |=> stat_q); // R7
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hit && !frame_start_i) |=> !stat_q); // R7
endmodule

// File: rtl/dtg_axis.sv
module dtg_axis
  import dtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    run_i,
  input  logic                    step_i,
  input  logic                    load_i,
  input  logic [NSEG-1:0][CW-1:0] seg_new_i,
  output logic                    wrap_o,
  output logic                    at_zero_o,
  output logic                    in_sync_o,
  output logic                    in_act_o,
  output logic [CW-1:0]           coord_o
);
  localparam int PW = CW + 3;
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [NSEG-1:0][CW-1:0] seg_q, seg_d;
  logic [PW-1:0]           pos_q, pos_d;
  logic [PW-1:0]           edge_sync, edge_back, edge_act, total;
  logic [PW-1:0]           offs;
  logic                    last;

  function automatic logic [PW-1:0] widen(input logic [CW-1:0] v);
    return {{(PW-CW){1'b0}}, v};
  endfunction

  // exclusive end of each segment, in scan order
  assign edge_sync = widen(seg_q[SEG_SYNC]) + ONE;
  assign edge_back = edge_sync + widen(seg_q[SEG_BACK]) + ONE;
  assign edge_act  = edge_back + widen(seg_q[SEG_ACT]) + ONE;
  assign total     = edge_act + widen(seg_q[SEG_FRONT]) + ONE;
  assign last      = (pos_q == total - ONE);

  always_comb begin
    pos_d = pos_q;
    if (!run_i)      pos_d = '0;
    else if (step_i) pos_d = last ? '0 : pos_q + ONE;
    seg_d = load_i ? seg_new_i : seg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      seg_q <= '0;
    end else begin
      pos_q <= pos_d;
      seg_q <= seg_d;
    end
  end

  assign offs      = pos_q - edge_back;
  assign wrap_o    = run_i && step_i && last;
  assign at_zero_o = (pos_q == '0);
  assign in_sync_o = run_i && (pos_q < edge_sync);
  assign in_act_o  = run_i && (pos_q >= edge_back) && (pos_q < edge_act);
  assign coord_o   = in_act_o ? offs[CW-1:0] : '0;

  AST_POS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (pos_q < total)); // R1
  AST_IDLE_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (pos_q == '0)); // R5
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int CW = 12,
  parameter int DW = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [3:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [DW-1:0]     pix_data_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic              visible_o,
  output logic [CW-1:0]     pix_x_o,
  output logic [CW-1:0]     line_y_o,
  output logic [DW-1:0]     pix_data_o,
  output logic              irq_o
);
  logic                    run;
  logic [3:0]              pol;
  logic [NSEG-1:0][CW-1:0] hseg, vseg;
  logic                    h_wrap, v_wrap, h_zero, v_zero;
  logic                    h_sync, v_sync, h_act, v_act;
  logic [CW-1:0]           h_coord, v_coord;
  logic                    frame_start, load;
  logic                    vis;

  assign frame_start = run && h_zero && v_zero;
  assign load        = !run || v_wrap;

  dtg_regs #(.CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .frame_start_i(frame_start),
    .run_o(run), .pol_o(pol), .hseg_o(hseg), .vseg_o(vseg), .irq_o(irq_o)
  );

  dtg_axis #(.CW(CW)) u_h (
    .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(1'b1), .load_i(load),
    .seg_new_i(hseg), .wrap_o(h_wrap), .at_zero_o(h_zero),
    .in_sync_o(h_sync), .in_act_o(h_act), .coord_o(h_coord)
  );

  dtg_axis #(.CW(CW)) u_v (
    .clk(clk), .rst_n(rst_n), .run_i(run), .step_i(h_wrap), .load_i(load),
    .seg_new_i(vseg), .wrap_o(v_wrap), .at_zero_o(v_zero),
    .in_sync_o(v_sync), .in_act_o(v_act), .coord_o(v_coord)
  );

  assign vis        = h_act && v_act;
  assign visible_o  = vis;
  assign pix_x_o    = vis ? h_coord : '0;
  assign line_y_o   = vis ? v_coord : '0;
  assign hsync_o    = pol[POL_HS] ? h_sync : !h_sync;
  assign vsync_o    = pol[POL_VS] ? v_sync : !v_sync;
  assign de_o       = pol[POL_DE] ? vis : !vis;
  assign pix_data_o = vis ? (pol[POL_PD] ? pix_data_i : ~pix_data_i)
                          : {DW{!pol[POL_PD]}};

  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!visible_o && pix_x_o == '0 && line_y_o == '0)); // R4
  AST_SYNC_NOT_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    visible_o |-> (!h_sync && !v_sync)); // R1
  AST_START_AT_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (h_sync && v_sync)); // R5
  AST_VWRAP_ON_HWRAP: assert property (@(posedge clk) disable iff (!rst_n)
    v_wrap |-> h_wrap); // R2
endmodule

// File: tb/disp_timing_gen_tb_top.sv
module disp_timing_gen_tb_top;
  localparam int CW = 12;
  localparam int DW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_i = 1'b0;
  logic [3:0]    reg_addr_i = '0;
  logic [31:0]   reg_wdata_i = '0;
  logic [31:0]   reg_rdata_o;
  logic [DW-1:0] pix_data_i = '0;
  logic          hsync_o, vsync_o, de_o, visible_o, irq_o;
  logic [CW-1:0] pix_x_o, line_y_o;
  logic [DW-1:0] pix_data_o;

  always #4 clk = ~clk;

  disp_timing_gen #(.CW(CW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .pix_data_i(pix_data_i), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .visible_o(visible_o), .pix_x_o(pix_x_o),
    .line_y_o(line_y_o), .pix_data_o(pix_data_o), .irq_o(irq_o)
  );

  // behavioural reference state
  int m_run, m_h, m_v, m_stat, m_mask, m_pol;
  int m_ah[4], m_av[4], m_sh[4], m_sv[4];
  int t_fs, t_ht, t_vt;
  int vectors = 0, errors = 0, cycles = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_h = 0; m_v = 0; m_stat = 0; m_mask = 0; m_pol = 0;
      for (int i = 0; i < 4; i++) begin
        m_ah[i] = 0; m_av[i] = 0; m_sh[i] = 0; m_sv[i] = 0;
      end
    end else begin
      t_fs = (m_run != 0 && m_h == 0 && m_v == 0) ? 1 : 0;
      t_ht = m_ah[0] + m_ah[1] + m_ah[2] + m_ah[3] + 4;
      t_vt = m_av[0] + m_av[1] + m_av[2] + m_av[3] + 4;
      if (m_run == 0) begin
        m_h = 0; m_v = 0; m_ah = m_sh; m_av = m_sv;
      end else if (m_h == t_ht - 1) begin
        m_h = 0;
        if (m_v == t_vt - 1) begin
          m_v = 0; m_ah = m_sh; m_av = m_sv;
        end else m_v++;
      end else m_h++;
      if (reg_wr_i && reg_addr_i == 4'h1 && reg_wdata_i[0]) m_stat = 0;
      if (t_fs != 0) m_stat = 1;
      if (reg_wr_i) begin
        case (reg_addr_i)
          4'h0: m_run  = int'(reg_wdata_i[0]);
          4'h2: m_mask = int'(reg_wdata_i[0]);
          4'h3: m_pol  = int'(reg_wdata_i[3:0]);
          4'h4, 4'h5, 4'h6, 4'h7: m_sh[reg_addr_i - 4] = int'(reg_wdata_i[CW-1:0]);
          4'h8, 4'h9, 4'hA, 4'hB: m_sv[reg_addr_i - 8] = int'(reg_wdata_i[CW-1:0]);
          default: ;
        endcase
      end
    end
  end

  // expected outputs from the model state
  int e_hs_in, e_vs_in, e_hact, e_vact, e_vis, e_x, e_y, e_rd;
  logic [DW-1:0] e_data;

  task automatic expect_now();
    int hb = m_ah[0] + m_ah[1] + 2;
    int vb = m_av[0] + m_av[1] + 2;
    e_hs_in = (m_run != 0 && m_h < m_ah[0] + 1) ? 1 : 0;
    e_vs_in = (m_run != 0 && m_v < m_av[0] + 1) ? 1 : 0;
    e_hact  = (m_run != 0 && m_h >= hb && m_h < hb + m_ah[2] + 1) ? 1 : 0;
    e_vact  = (m_run != 0 && m_v >= vb && m_v < vb + m_av[2] + 1) ? 1 : 0;
    e_vis   = e_hact & e_vact;
    e_x     = e_vis != 0 ? m_h - hb : 0;
    e_y     = e_vis != 0 ? m_v - vb : 0;
    if (e_vis != 0) e_data = m_pol[3] ? pix_data_i : ~pix_data_i;
    else            e_data = m_pol[3] ? '0 : '1;
    case (reg_addr_i)
      4'h0: e_rd = m_run;
      4'h1: e_rd = m_stat;
      4'h2: e_rd = m_mask;
      4'h3: e_rd = m_pol;
      4'h4, 4'h5, 4'h6, 4'h7: e_rd = m_sh[reg_addr_i - 4];
      4'h8, 4'h9, 4'hA, 4'hB: e_rd = m_sv[reg_addr_i - 8];
      default: e_rd = 0;
    endcase
  endtask

  task automatic cmp(input int act, input int exp, input string what);
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", what, act, exp, $time);
    end
  endtask

  // every-cycle comparison, 2 ns after the active edge
  always @(posedge clk) begin
    #2;
    if (!done) begin
      expect_now();
      vectors++;
      cmp(int'(hsync_o), m_pol[0] ? e_hs_in : 1 - e_hs_in, "R1 R3 R9 hsync");
      cmp(int'(vsync_o), m_pol[1] ? e_vs_in : 1 - e_vs_in, "R2 R3 vsync");
      cmp(int'(de_o), m_pol[2] ? e_vis : 1 - e_vis, "R3 R9 data-enable");
      cmp(int'(visible_o), e_vis, "R6 R9 visible");
      cmp(int'(pix_x_o), e_x, "R6 R9 pixel x");
      cmp(int'(line_y_o), e_y, "R6 line y");
      cmp(int'(pix_data_o), int'(e_data), "R3 R4 pixel data");
      cmp(int'(irq_o), m_stat & m_mask, "R7 R8 irq");
      cmp(int'(reg_rdata_o), e_rd, "R10 R7 read data");
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input int d);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic cycles_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pix_data_i = pix_data_i + 24'h01_3A_57;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cycles, 20000);
      finish_run();
    end
  end

  localparam int FRAME = 11 * 7;

  initial begin
    repeat (3) @(negedge clk);
    // reset state: polarity 0 means active-low, so idle levels are high
    chk(hsync_o == 1'b1 && vsync_o == 1'b1 && de_o == 1'b1, "R4 reset idle sync", int'(hsync_o), 1);
    chk(irq_o == 1'b0 && visible_o == 1'b0, "R8 reset irq", int'(irq_o), 0);
    rst_n = 1'b1;
    wr(4'h4, 1); wr(4'h5, 2); wr(4'h6, 3); wr(4'h7, 1);
    wr(4'h8, 0); wr(4'h9, 1); wr(4'hA, 2); wr(4'hB, 0);
    wr(4'h3, 4'hF); wr(4'h2, 1);
    wr(4'h0, 1);
    chk(hsync_o == 1'b1 && vsync_o == 1'b1, "R5 start at sync origin", int'({hsync_o, vsync_o}), 3);
    cycles_n(3 * FRAME);
    reg_addr_i = 4'h1;
    @(negedge clk);
    chk(reg_rdata_o[0] == 1'b1, "R7 status after frames", int'(reg_rdata_o[0]), 1);
    chk(irq_o == 1'b1, "R8 irq with mask set", int'(irq_o), 1);
    wr(4'h1, 1);
    // R9: rewrite the active width in the middle of a frame
    while (!(m_h == 5 && m_v == 3)) @(negedge clk);
    wr(4'h6, 5);
    reg_addr_i = 4'h6;
    @(negedge clk);
    chk(reg_rdata_o[CW-1:0] == 12'd5, "R10 timing readback", int'(reg_rdata_o), 5);
    cycles_n(4 * FRAME);
    wr(4'h3, 4'h5); wr(4'h2, 0);
    cycles_n(2 * FRAME);
    chk(irq_o == 1'b0, "R8 irq masked", int'(irq_o), 0);
    // R7: clear write on the same edge as the frame-start set
    wr(4'h2, 1);
    while (!(m_run != 0 && m_h == 0 && m_v == 0)) @(negedge clk);
    reg_wr_i = 1'b1; reg_addr_i = 4'h1; reg_wdata_i = 1;
    @(negedge clk);
    reg_wr_i = 1'b0;
    chk(reg_rdata_o[0] == 1'b1, "R7 set wins over clear", int'(reg_rdata_o[0]), 1);
    cycles_n(FRAME / 2);
    wr(4'h0, 0);
    // polarity 0x5: hsync and data enable active-high, vsync and data active-low
    chk(hsync_o == 1'b0 && de_o == 1'b0, "R4 stopped hsync/de idle", int'({hsync_o, de_o}), 0);
    chk(vsync_o == 1'b1, "R4 stopped vsync idle", int'(vsync_o), 1);
    cycles_n(20);
    chk(pix_data_o == '1 && visible_o == 1'b0, "R4 stopped data idle", int'(pix_data_o), 24'hFFFFFF);
    wr(4'h0, 1);
    chk(hsync_o == 1'b1 && vsync_o == 1'b0, "R5 restart at sync origin", int'({hsync_o, vsync_o}), 2);
    cycles_n(2 * FRAME);
    finish_run();
  end
endmodule